// File: doc/BRIEF.md
# Receive Path Reset Sequencer

This block brings a serial transceiver's receive path out of reset. It runs after power-up, after an external reset, and after a fault. It has two reset outputs. One resets the physical-medium attachment (PMA). The other resets the receive PCS. The sequencer releases them in order and raises a ready flag only after the link has run cleanly for a set number of cycles.

The sequencer watches three inputs in the user-clock domain: the CDR lock indication, a flag that says the receive user clocks are stable, and a receive error flag. A mode pin selects how lock is judged.
- In analog CDR mode, lock must stay high for a minimum number of consecutive reference-clock cycles before the PCS is reset. That duration is measured in the reference-clock domain and passed back to the user-clock domain through a two-flop synchronizer.
- In digital CDR mode, no minimum applies.

Receive errors seen while the link is settling cause another PCS reset. When these retries keep failing, the sequencer escalates to a full PMA reset.

Top module: `rx_bringup_seq`

## Requirements
- R1: While `rst_i` is high, `pma_rst_o` is 1 and both `pcs_rst_o` and `ready_o` are 0. Counted from the first user-clock cycle in which `rst_i` is low, `pma_rst_o` stays high for exactly `PMA_RST_CYCLES` cycles (default 3). Each PMA reset entry lasts the same number of cycles.
- R2: `pma_rst_o` and `pcs_rst_o` are never high in the same cycle.
- R3: In digital mode (`analog_mode_i` = 0), the wait-for-lock state moves on to the PCS reset only when `lock_i` and `clk_stable_i` are both high. `rx_err_i` has no effect in this state.
- R4: In analog mode (`analog_mode_i` = 1), the PCS reset starts only after `lock_i` has been high for `LOCK_CYCLES` consecutive reference-clock cycles. If lock drops for at least 8 user-clock cycles, the count restarts from zero.
- R5: A PCS reset pulse that is not cut short by loss of lock lasts exactly `PCS_RST_CYCLES` user-clock cycles (default 3).
- R6: While lock stays high and no error occurs, `ready_o` rises after `PCS_WAIT_CYCLES + STABLE_CYCLES` cycles (default 5 + 64 = 69), counted from the first cycle with `pcs_rst_o` low after the pulse.
- R7: Loss of lock during the PCS reset, the post-reset wait or the settling window returns the sequencer to wait-for-lock. `ready_o` does not rise. A fresh PCS reset pulse follows once lock returns.
- R8: An error seen with lock high during the settling window produces a new PCS reset. `pcs_rst_o` is high in the next cycle.
- R9: The `MAX_PCS_TRIES`-th such error (default 16) raises `pma_rst_o` instead of `pcs_rst_o`. The PMA reset clears the attempt count, so the next error gives a PCS reset again.
- R10: `ready_o` is high only in the ready state. When `lock_i` drops while ready, `ready_o` is low in the next cycle.
- R11: `rx_err_i` has no effect once `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usr_clk_i | input | 1 | Receive user clock; the sequencer runs on it |
| ref_clk_i | input | 1 | Reference clock used for the lock-duration count |
| rst_i | input | 1 | Synchronous active-high reset (user-clock domain); starts the sequence with a PMA reset |
| analog_mode_i | input | 1 | 1 = analog CDR (minimum lock duration applies), 0 = digital CDR |
| lock_i | input | 1 | CDR lock indication, synchronous to `usr_clk_i` |
| clk_stable_i | input | 1 | Receive user clocks are stable |
| rx_err_i | input | 1 | Receive error flag |
| pma_rst_o | output | 1 | PMA reset request |
| pcs_rst_o | output | 1 | Receive PCS reset request |
| ready_o | output | 1 | Receive link ready for data |

## Verification
The bench builds the sequencer with `LOCK_CYCLES` = 40 and keeps the other parameters at their defaults. The short lock window makes the analog-mode timing reachable in a few hundred nanoseconds, including a lock drop that restarts the count. Because `MAX_PCS_TRIES` stays at 16, the full run of sixteen failed settling attempts, the escalation to a PMA reset and the cleared attempt count that follows are all exercised. The default 3/5/64 windows let the bench check exact pulse widths and the 69-cycle settling delay cycle by cycle.

// File: rtl/rxseq_pkg.sv
`timescale 1ns/1ps
package rxseq_pkg;

    typedef enum logic [2:0] {
        ST_PMA_RST   = 3'd0,
        ST_WAIT_LOCK = 3'd1,
        ST_PCS_RST   = 3'd2,
        ST_PCS_WAIT  = 3'd3,
        ST_SETTLE    = 3'd4,
        ST_READY     = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic pma_rst;
        logic pcs_rst;
        logic ready;
    } seq_out_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic seq_out_t decode_outputs(input seq_state_e s);
        seq_out_t o;
        o.pma_rst = (s == ST_PMA_RST);
        o.pcs_rst = (s == ST_PCS_RST);
        o.ready   = (s == ST_READY);
        return o;
    endfunction

endpackage

// File: rtl/rxseq_sync2.sv
`timescale 1ns/1ps
module rxseq_sync2 (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i) begin
        meta_q <= d_i;
        sync_q <= meta_q;
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rxseq_lock_timer.sv
`timescale 1ns/1ps
module rxseq_lock_timer #(
    parameter int LOCK_CYCLES = 16384
) (
    input  logic ref_clk_i,
    input  logic rst_ref_i,
    input  logic lock_i,
    output logic met_o
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic          lock_ref;
    logic [CW-1:0] run_q;
    logic          met_q;

    rxseq_sync2 u_lock_sync (
        .clk_i (ref_clk_i),
        .d_i   (lock_i),
        .q_o   (lock_ref)
    );

    // Counts consecutive reference cycles of lock; any drop restarts the run.
    always_ff @(posedge ref_clk_i) begin
        if (rst_ref_i || !lock_ref) begin
            run_q <= '0;
        end else if (run_q != CW'(LOCK_CYCLES)) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_ff @(posedge ref_clk_i) begin
        if (rst_ref_i) met_q <= 1'b0;
        else           met_q <= (run_q == CW'(LOCK_CYCLES));
    end

    assign met_o = met_q;
endmodule

// File: rtl/rxseq_fsm.sv
`timescale 1ns/1ps
module rxseq_fsm
    import rxseq_pkg::*;
#(
    parameter int PMA_RST_CYCLES  = 3,
    parameter int PCS_RST_CYCLES  = 3,
    parameter int PCS_WAIT_CYCLES = 5,
    parameter int STABLE_CYCLES   = 64,
    parameter int MAX_PCS_TRIES   = 16
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     analog_mode_i,
    input  logic     lock_i,
    input  logic     clk_stable_i,
    input  logic     rx_err_i,
    input  logic     lock_met_i,
    output seq_out_t out_o
);
    localparam int CNT_MAX = max_of4(PMA_RST_CYCLES, PCS_RST_CYCLES,
                                     PCS_WAIT_CYCLES, STABLE_CYCLES);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam int TW = $clog2(MAX_PCS_TRIES + 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] tries_q, tries_d;
    logic          lock_ok;

    assign lock_ok = lock_i && clk_stable_i && (!analog_mode_i || lock_met_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        tries_d = tries_q;
        unique case (state_q)
            ST_PMA_RST: begin
                tries_d = '0;
                if (cnt_q == CW'(PMA_RST_CYCLES - 1)) begin
                    state_d = ST_WAIT_LOCK;
                    cnt_d   = '0;
                end
            end
            ST_WAIT_LOCK: begin
                cnt_d = '0;
                if (lock_ok) state_d = ST_PCS_RST;
            end
            ST_PCS_RST: begin
                if (!lock_i) begin
                    state_d = ST_WAIT_LOCK;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(PCS_RST_CYCLES - 1)) begin
                    state_d = ST_PCS_WAIT;
                    cnt_d   = '0;
                end
            end
            ST_PCS_WAIT: begin
                if (!lock_i) begin
                    state_d = ST_WAIT_LOCK;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(PCS_WAIT_CYCLES - 1)) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end
            end
            ST_SETTLE: begin
                if (!lock_i) begin
                    state_d = ST_WAIT_LOCK;
                    cnt_d   = '0;
                end else if (rx_err_i) begin
                    cnt_d = '0;
                    if (tries_q == TW'(MAX_PCS_TRIES - 1)) begin
                        state_d = ST_PMA_RST;
                    end else begin
                        state_d = ST_PCS_RST;
                        tries_d = tries_q + 1'b1;
                    end
                end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
                    state_d = ST_READY;
                    cnt_d   = '0;
                end
            end
            ST_READY: begin
                cnt_d = '0;
                if (!lock_i) state_d = ST_WAIT_LOCK;
            end
            default: begin
                state_d = ST_PMA_RST;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_PMA_RST;
            cnt_q   <= '0;
            tries_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tries_q <= tries_d;
        end
    end

    assign out_o = decode_outputs(state_q);
endmodule

// File: rtl/rx_bringup_seq.sv
`timescale 1ns/1ps
module rx_bringup_seq
    import rxseq_pkg::*;
#(
    parameter int LOCK_CYCLES     = 16384,
    parameter int PMA_RST_CYCLES  = 3,
    parameter int PCS_RST_CYCLES  = 3,
    parameter int PCS_WAIT_CYCLES = 5,
    parameter int STABLE_CYCLES   = 64,
    parameter int MAX_PCS_TRIES   = 16
) (
    input  logic usr_clk_i,
    input  logic ref_clk_i,
    input  logic rst_i,
    input  logic analog_mode_i,
    input  logic lock_i,
    input  logic clk_stable_i,
    input  logic rx_err_i,
    output logic pma_rst_o,
    output logic pcs_rst_o,
    output logic ready_o
);
    logic     rst_ref;
    logic     met_ref;
    logic     met_usr;
    seq_out_t seq_out;

    rxseq_sync2 u_rst_sync (
        .clk_i (ref_clk_i),
        .d_i   (rst_i),
        .q_o   (rst_ref)
    );

    rxseq_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock_timer (
        .ref_clk_i (ref_clk_i),
        .rst_ref_i (rst_ref),
        .lock_i    (lock_i),
        .met_o     (met_ref)
    );

    rxseq_sync2 u_met_sync (
        .clk_i (usr_clk_i),
        .d_i   (met_ref),
        .q_o   (met_usr)
    );

    rxseq_fsm #(
        .PMA_RST_CYCLES  (PMA_RST_CYCLES),
        .PCS_RST_CYCLES  (PCS_RST_CYCLES),
        .PCS_WAIT_CYCLES (PCS_WAIT_CYCLES),
        .STABLE_CYCLES   (STABLE_CYCLES),
        .MAX_PCS_TRIES   (MAX_PCS_TRIES)
    ) u_fsm (
        .clk_i         (usr_clk_i),
        .rst_i         (rst_i),
        .analog_mode_i (analog_mode_i),
        .lock_i        (lock_i),
        .clk_stable_i  (clk_stable_i),
        .rx_err_i      (rx_err_i),
        .lock_met_i    (met_usr),
        .out_o         (seq_out)
    );

    assign pma_rst_o = seq_out.pma_rst;
    assign pcs_rst_o = seq_out.pcs_rst;
    assign ready_o   = seq_out.ready;
endmodule

// File: rtl/rxseq_checker.sv
`timescale 1ns/1ps
module rxseq_checker #(
    parameter int PCS_RST_CYCLES = 3
) (
    input logic clk_i,
    input logic rst_i,
    input logic lock_i,
    input logic rx_err_i,
    input logic pma_rst_o,
    input logic pcs_rst_o,
    input logic ready_o
);
    logic [7:0] pcs_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          pcs_run_q <= '0;
        else if (pcs_rst_o) pcs_run_q <= pcs_run_q + 1'b1;
        else                pcs_run_q <= '0;
    end

    p_exclusive_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pma_rst_o && pcs_rst_o));

    p_pcs_entry_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pcs_rst_o) |-> $past(lock_i));

    p_pcs_width_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pcs_rst_o) && $past(lock_i) |-> pcs_run_q == 8'(PCS_RST_CYCLES));

    p_ready_entry_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> $past(lock_i) && !$past(rx_err_i));

    p_pma_entry_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pma_rst_o) |-> $past(rx_err_i));

    p_lock_drop_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o && !lock_i |=> !ready_o);
endmodule

bind rx_bringup_seq rxseq_checker #(
    .PCS_RST_CYCLES (PCS_RST_CYCLES)
) u_checker (
    .clk_i     (usr_clk_i),
    .rst_i     (rst_i),
    .lock_i    (lock_i),
    .rx_err_i  (rx_err_i),
    .pma_rst_o (pma_rst_o),
    .pcs_rst_o (pcs_rst_o),
    .ready_o   (ready_o)
);

// File: tb/rx_bringup_seq_tb.sv
`timescale 1ns/1ps
module rx_bringup_seq_tb;
    localparam int LOCK_TB = 40;

    logic usr_clk = 1'b0;
    logic ref_clk = 1'b0;
    always #4 usr_clk = ~usr_clk;
    always #5 ref_clk = ~ref_clk;

    logic rst, analog, lock, stable, err;
    logic pma, pcs, rdy;

    int n_checks = 0;
    int n_fail   = 0;

    rx_bringup_seq #(.LOCK_CYCLES(LOCK_TB)) u_dut (
        .usr_clk_i     (usr_clk),
        .ref_clk_i     (ref_clk),
        .rst_i         (rst),
        .analog_mode_i (analog),
        .lock_i        (lock),
        .clk_stable_i  (stable),
        .rx_err_i      (err),
        .pma_rst_o     (pma),
        .pcs_rst_o     (pcs),
        .ready_o       (rdy)
    );

    // stimulus {lock, stable, err, expect_pcs_pulse} applied in wait-for-lock
    localparam logic [3:0] VEC [6] = '{4'b0000, 4'b0100, 4'b1000,
                                       4'b1010, 4'b1111, 4'b1101};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge usr_clk);
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0:       return pma;
            1:       return pcs;
            default: return rdy;
        endcase
    endfunction

    task automatic count_high(input int sel, output int n);
        n = 0;
        while (pick(sel) && n < 1000) begin
            n++;
            tick(1);
        end
    endtask

    task automatic wait_for(input int sel, input logic val, input int limit, output bit ok);
        int k;
        k = 0;
        while (pick(sel) !== val && k < limit) begin
            k++;
            tick(1);
        end
        ok = (pick(sel) === val);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int  n;
        bit  ok;
        bit  seen;
        bit  bad;
        time t0, t1;

        rst = 1'b1; analog = 1'b0; lock = 1'b1; stable = 1'b1; err = 1'b0;
        tick(4);
        check({pma, pcs, rdy} == 3'b100, "R1 reset state", int'({pma, pcs, rdy}), 4);

        rst = 1'b0;
        count_high(0, n);
        check(n == 3, "R1 pma pulse width", n, 3);

        wait_for(1, 1'b1, 20, ok);
        check(ok, "R3 pcs reset after lock and stable", int'(ok), 1);
        count_high(1, n);
        check(n == 3, "R5 pcs pulse width", n, 3);
        n = 0;
        while (!rdy && n < 1000) begin n++; tick(1); end
        check(n == 69, "R6 settle delay", n, 69);
        check(rdy == 1'b1, "R10 ready high", int'(rdy), 1);

        // R11: error while ready is ignored
        err = 1'b1; tick(1); err = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!rdy || pcs || pma) bad = 1'b1;
            tick(1);
        end
        check(!bad, "R11 error ignored while ready", int'(bad), 0);

        // R3: vector table walked in wait-for-lock (digital mode)
        for (int v = 0; v < 6; v++) begin
            lock = 1'b0; stable = 1'b1; err = 1'b0;
            tick(3);
            {lock, stable, err} = VEC[v][3:1];
            seen = 1'b0;
            for (int c = 0; c < 6; c++) begin
                tick(1);
                if (pcs) seen = 1'b1;
            end
            check(seen == VEC[v][0], $sformatf("R3 wait gate vector %0d", v),
                  int'(seen), int'(VEC[v][0]));
        end
        lock = 1'b1; stable = 1'b1; err = 1'b0;
        wait_for(2, 1'b1, 300, ok);
        check(ok, "R6 ready after table", int'(ok), 1);

        // R10: lock loss while ready
        lock = 1'b0; tick(1);
        check(rdy == 1'b0, "R10 ready drops after lock loss", int'(rdy), 0);
        tick(2); lock = 1'b1;

        // R7: lock loss during post-reset wait
        wait_for(1, 1'b1, 20, ok);
        wait_for(1, 1'b0, 20, ok);
        tick(2); lock = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (rdy || pcs) bad = 1'b1;
            tick(1);
        end
        check(!bad, "R7 idle while lock lost", int'(bad), 0);
        lock = 1'b1;
        wait_for(1, 1'b1, 10, ok);
        check(ok, "R7 new pcs pulse after lock returns", int'(ok), 1);

        // R7: lock loss during settling window
        wait_for(1, 1'b0, 20, ok);
        tick(8); lock = 1'b0; tick(1); lock = 1'b1;
        bad = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (rdy) bad = 1'b1;
            if (pcs) seen = 1'b1;
            tick(1);
        end
        check(seen && !bad, "R7 settle restart after lock loss", int'(seen), 1);

        // R8: error in settling window
        wait_for(1, 1'b0, 20, ok);
        tick(8); err = 1'b1; tick(1);
        check(pcs == 1'b1 && pma == 1'b0, "R8 pcs reset after error", int'(pcs), 1);
        err = 1'b0;
        count_high(1, n);
        check(n == 3, "R5 retry pcs width", n, 3);

        // R9: escalation after 16 failed attempts
        rst = 1'b1; tick(3); rst = 1'b0;
        wait_for(0, 1'b0, 20, ok);
        for (int i = 0; i < 16; i++) begin
            wait_for(1, 1'b1, 20, ok);
            wait_for(1, 1'b0, 20, ok);
            tick(8); err = 1'b1; tick(1);
            if (i < 15) begin
                check(pcs && !pma, $sformatf("R9 attempt %0d pcs retry", i), int'(pcs), 1);
                err = 1'b0;
            end else begin
                check(pma && !pcs, "R9 escalate to pma", int'(pma), 1);
                err = 1'b0;
                count_high(0, n);
                check(n == 3, "R1 R9 escalated pma width", n, 3);
            end
        end
        wait_for(1, 1'b1, 20, ok);
        wait_for(1, 1'b0, 20, ok);
        tick(8); err = 1'b1; tick(1);
        check(pcs && !pma, "R9 attempt count cleared", int'(pcs), 1);
        err = 1'b0;

        // R4: analog mode minimum lock duration with restart
        analog = 1'b1; lock = 1'b0;
        tick(10);
        lock = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 15; i++) begin
            if (pcs) seen = 1'b1;
            tick(1);
        end
        check(!seen, "R4 no pcs before lock duration", int'(seen), 0);
        lock = 1'b0; tick(10); lock = 1'b1;
        t0 = $time;
        wait_for(1, 1'b1, 200, ok);
        t1 = $time;
        check(ok && (t1 - t0) >= LOCK_TB * 10 && (t1 - t0) <= LOCK_TB * 10 + 120,
              "R4 lock duration ns", int'(t1 - t0), LOCK_TB * 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule